// File: doc/BRIEF.md
# USB Hub Downstream Port Monitor

This block watches the downstream ports of a USB hub (seven by default). Each port arrives as a pair of synchronized line levels. A per-port filter measures how long the pair has stayed in single-ended zero (both lines low) or out of it. When a port has been out of SE0 for long enough, the block marks the port attached and records its speed from which line idles high. When a port has stayed in SE0 for a shorter window, the block marks it detached. Each attach or detach produces a one-cycle hub interrupt pulse, whether or not the port is enabled.

Firmware reaches four registers through a simple select/write/read interface: attach status, speed, enable, and a 2-bit-per-port drive-force code. A write that turns a port on is held back while a packet is in flight and lands at the first idle cycle. Turning a port off takes effect at once. At the EOF2 strobe, hardware drops the enable of any port that is babbling.

A USB bus reset clears attach, speed, enable and any held-back enables. It leaves the force codes alone. Only the full synchronous reset clears those.

Top module: `hub_port_monitor`

## Requirements
- R1: After `rst`, every register reads 0, `hub_irq` is 0 and no port is driven (`drive_en` all 0); `rst` also clears the force codes.
- R2: A port's attach bit (select 0) sets at the clock edge that takes the CONN_CYCLES-th consecutive non-SE0 sample (default 30). Any SE0 sample restarts the count.
- R3: On attach, the speed bit (select 1) becomes 1 if the port shows D- high with D+ low (low-speed), and 0 if D+ is high (full-speed).
- R4: An attached port's attach bit clears at the edge that takes the DISC_CYCLES-th consecutive SE0 sample (default 24). Its speed bit is left unchanged.
- R5: `hub_irq` is high for exactly the one cycle after each edge on which any attach bit changes, independent of the enable bits, and is low otherwise.
- R6: A firmware write to the speed register (select 1) replaces the speed bits. The next attach of a port overwrites only that port's bit.
- R7: An enable write (select 2) clears bits immediately. Bits it sets apply at the write edge if `pkt_active` is low, else at the first edge that samples `pkt_active` low. A later write replaces pending sets.
- R8: On a cycle with `eof2_strobe` high, the enable bit of every port with `ds_nonidle` or `us_linked` set is cleared. Those inputs have no effect without the strobe.
- R9: Port p's force code sits at bits [2p+1:2p] of select 3. Code 0 releases the pins. Code 1 drives D+ high and D- low. Code 2 drives D+ low and D- high. Code 3 drives both low. Any nonzero code sets `drive_en`.
- R10: `bus_reset` clears attach, speed, enable and pending enables within one edge and raises no interrupt. It leaves the force codes unchanged. Attach detection then restarts from zero samples.
- R11: Writes to the attach register are ignored. Bits at and above NPORTS read 0 in the attach, speed and enable registers.
- R12: `reg_sel` encodes 0 attach, 1 speed, 2 enable, 3 force. `reg_rdata` follows `reg_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| bus_reset | input | 1 | USB bus reset seen upstream |
| line_dp | input | NPORTS | Synchronized D+ level per port |
| line_dm | input | NPORTS | Synchronized D- level per port |
| pkt_active | input | 1 | A packet is in flight through the repeater |
| eof2_strobe | input | 1 | One-cycle pulse at the EOF2 point of a frame |
| ds_nonidle | input | NPORTS | Port shows non-idle downstream traffic |
| us_linked | input | NPORTS | Port still linked upstream, no EOP seen |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 2*NPORTS | Register write data |
| reg_rdata | output | 2*NPORTS | Register read data |
| hub_irq | output | 1 | Hub interrupt pulse |
| drive_en | output | NPORTS | Force drive active per port |
| drive_dp | output | NPORTS | Forced D+ level per port |
| drive_dm | output | NPORTS | Forced D- level per port |

## Verification
Every result here is due a fixed number of edges after its stimulus. An attach appears on the CONN_CYCLES-th edge after the lines leave SE0, and a detach on the DISC_CYCLES-th edge after they enter it. The interrupt pulse shares that edge and falls on the next. Register writes, babble clearing and bus reset act on the one edge that samples them. A held-back enable lands on the first edge that samples `pkt_active` low. Force decoding follows the write edge with no further delay. The bench drives and reads only between rising edges. It probes attach status one edge before and on the due edge, and it checks each register on the first read window after the edge that should change it.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [1:0] {
        SEL_ATTACH = 2'd0,
        SEL_SPEED  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_FORCE  = 2'd3
    } hpm_sel_e;

    typedef enum logic [1:0] {
        FRC_RELEASE = 2'd0,
        FRC_DP_HIGH = 2'd1,
        FRC_DM_HIGH = 2'd2,
        FRC_BOTH_LO = 2'd3
    } hpm_force_e;

    typedef struct packed {
        logic oe;
        logic dp;
        logic dm;
    } hpm_drive_t;

    typedef struct packed {
        logic attach;
        logic detach;
        logic low_speed;
    } hpm_line_evt_t;

    function automatic hpm_drive_t force_decode(input logic [1:0] code);
        hpm_drive_t d;
        d = '0;
        unique case (hpm_force_e'(code))
            FRC_RELEASE: d = '0;
            FRC_DP_HIGH: begin d.oe = 1'b1; d.dp = 1'b1; end
            FRC_DM_HIGH: begin d.oe = 1'b1; d.dm = 1'b1; end
            FRC_BOTH_LO: d.oe = 1'b1;
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hpm_line_filter.sv
module hpm_line_filter
    import hpm_pkg::*;
#(
    parameter int CONN_CYCLES = 30,
    parameter int DISC_CYCLES = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          dp,
    input  logic          dm,
    output logic          attached,
    output hpm_line_evt_t evt
);
    localparam int CNT_MAX = (CONN_CYCLES > DISC_CYCLES) ? CONN_CYCLES : DISC_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic          se0;
    logic          se0_q;
    logic [CW-1:0] run_q;
    logic          att_q;
    logic          same;
    logic          hit_att;
    logic          hit_det;

    assign se0  = ~dp & ~dm;
    assign same = (se0 == se0_q);

    // run_q counts consecutive samples of the level held in se0_q
    assign hit_att = ~clear & ~att_q & ~se0 & same & (run_q == CW'(CONN_CYCLES - 1));
    assign hit_det = ~clear &  att_q &  se0 & same & (run_q == CW'(DISC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            se0_q <= 1'b1;
            run_q <= '0;
            att_q <= 1'b0;
        end else begin
            if (!same) begin
                se0_q <= se0;
                run_q <= CW'(1);
            end else if (run_q != CW'(CNT_MAX)) begin
                run_q <= run_q + CW'(1);
            end
            if (hit_att)
                att_q <= 1'b1;
            else if (hit_det)
                att_q <= 1'b0;
        end
    end

    assign attached      = att_q;
    assign evt.attach    = hit_att;
    assign evt.detach    = hit_det;
    assign evt.low_speed = dm & ~dp;

endmodule

// File: rtl/hpm_enable_ctl.sv
module hpm_enable_ctl #(
    parameter int NPORTS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr,
    input  logic [NPORTS-1:0] wdata,
    input  logic              pkt_active,
    input  logic              eof2_strobe,
    input  logic [NPORTS-1:0] babble,
    output logic [NPORTS-1:0] enable
);
    logic [NPORTS-1:0] en_q, pend_q;
    logic [NPORTS-1:0] en_n, pend_n;

    always_comb begin
        en_n   = en_q;
        pend_n = pend_q;
        if (wr) begin
            en_n   = en_q & wdata;      // clears land now
            pend_n = wdata & ~en_q;     // sets wait for an idle bus
        end
        if (!pkt_active) begin
            en_n   = en_n | pend_n;
            pend_n = '0;
        end
        if (eof2_strobe) begin
            en_n   = en_n & ~babble;
            pend_n = pend_n & ~babble;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
        end
    end

    assign enable = en_q;

endmodule

// File: rtl/hpm_force_bank.sv
module hpm_force_bank
    import hpm_pkg::*;
#(
    parameter int NPORTS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [2*NPORTS-1:0] wdata,
    output logic [2*NPORTS-1:0] codes,
    output logic [NPORTS-1:0]   drive_en,
    output logic [NPORTS-1:0]   drive_dp,
    output logic [NPORTS-1:0]   drive_dm
);
    logic [2*NPORTS-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (wr)
            code_q <= wdata;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        hpm_drive_t drv;
        assign drv         = force_decode(code_q[2*p +: 2]);
        assign drive_en[p] = drv.oe;
        assign drive_dp[p] = drv.dp;
        assign drive_dm[p] = drv.dm;
    end

    assign codes = code_q;

endmodule

// File: rtl/hub_port_monitor.sv
module hub_port_monitor
    import hpm_pkg::*;
#(
    parameter int NPORTS      = 7,
    parameter int CONN_CYCLES = 30,
    parameter int DISC_CYCLES = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_reset,
    input  logic [NPORTS-1:0]   line_dp,
    input  logic [NPORTS-1:0]   line_dm,
    input  logic                pkt_active,
    input  logic                eof2_strobe,
    input  logic [NPORTS-1:0]   ds_nonidle,
    input  logic [NPORTS-1:0]   us_linked,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [2*NPORTS-1:0] reg_wdata,
    output logic [2*NPORTS-1:0] reg_rdata,
    output logic                hub_irq,
    output logic [NPORTS-1:0]   drive_en,
    output logic [NPORTS-1:0]   drive_dp,
    output logic [NPORTS-1:0]   drive_dm
);
    localparam int DW = 2 * NPORTS;

    hpm_sel_e          sel;
    logic              wr_speed, wr_enable, wr_force;
    logic [NPORTS-1:0] conn_vec;
    logic [NPORTS-1:0] en_vec;
    logic [NPORTS-1:0] spd_q;
    logic [NPORTS-1:0] att_hit, det_hit, low_spd;
    logic [DW-1:0]     force_codes;
    logic              irq_q;
    hpm_line_evt_t     evt [NPORTS];

    assign sel       = hpm_sel_e'(reg_sel);
    assign wr_speed  = reg_wr && (sel == SEL_SPEED);
    assign wr_enable = reg_wr && (sel == SEL_ENABLE);
    assign wr_force  = reg_wr && (sel == SEL_FORCE);

    for (genvar p = 0; p < NPORTS; p++) begin : g_line
        hpm_line_filter #(
            .CONN_CYCLES(CONN_CYCLES),
            .DISC_CYCLES(DISC_CYCLES)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .clear   (bus_reset),
            .dp      (line_dp[p]),
            .dm      (line_dm[p]),
            .attached(conn_vec[p]),
            .evt     (evt[p])
        );
        assign att_hit[p] = evt[p].attach;
        assign det_hit[p] = evt[p].detach;
        assign low_spd[p] = evt[p].low_speed;
    end

    hpm_enable_ctl #(.NPORTS(NPORTS)) u_en (
        .clk        (clk),
        .rst        (rst),
        .clear      (bus_reset),
        .wr         (wr_enable),
        .wdata      (reg_wdata[NPORTS-1:0]),
        .pkt_active (pkt_active),
        .eof2_strobe(eof2_strobe),
        .babble     (ds_nonidle | us_linked),
        .enable     (en_vec)
    );

    hpm_force_bank #(.NPORTS(NPORTS)) u_frc (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_force),
        .wdata   (reg_wdata),
        .codes   (force_codes),
        .drive_en(drive_en),
        .drive_dp(drive_dp),
        .drive_dm(drive_dm)
    );

    // speed: firmware value holds until a port's own attach overwrites it
    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            spd_q <= '0;
        end else begin
            if (wr_speed)
                spd_q <= reg_wdata[NPORTS-1:0];
            for (int p = 0; p < NPORTS; p++)
                if (att_hit[p])
                    spd_q[p] <= low_spd[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset)
            irq_q <= 1'b0;
        else
            irq_q <= |(att_hit | det_hit);
    end

    assign hub_irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_ATTACH: reg_rdata[NPORTS-1:0] = conn_vec;
            SEL_SPEED:  reg_rdata[NPORTS-1:0] = spd_q;
            SEL_ENABLE: reg_rdata[NPORTS-1:0] = en_vec;
            SEL_FORCE:  reg_rdata             = force_codes;
            default:    reg_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/hub_port_monitor_chk.sv
module hub_port_monitor_chk #(
    parameter int NPORTS = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_reset,
    input logic                pkt_active,
    input logic                eof2_strobe,
    input logic [NPORTS-1:0]   ds_nonidle,
    input logic [NPORTS-1:0]   us_linked,
    input logic [NPORTS-1:0]   conn,
    input logic [NPORTS-1:0]   en,
    input logic                hub_irq,
    input logic [NPORTS-1:0]   drive_en,
    input logic [NPORTS-1:0]   drive_dp,
    input logic [NPORTS-1:0]   drive_dm,
    input logic [1:0]          reg_sel,
    input logic [2*NPORTS-1:0] reg_rdata
);

    assert_irq_tracks_attach_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_reset)) |-> (hub_irq == (conn != $past(conn))));

    assert_busreset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_reset)) |-> (conn == '0 && en == '0 && !hub_irq));

    assert_no_set_in_packet_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pkt_active)) |-> ((en & ~$past(en)) == '0));

    assert_babble_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(eof2_strobe)) |-> ((en & $past(ds_nonidle | us_linked)) == '0));

    assert_force_legal_R9: assert property (@(posedge clk) disable iff (rst)
        ((drive_dp & drive_dm) == '0) && (((drive_dp | drive_dm) & ~drive_en) == '0));

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_sel != 2'd3) |-> ((reg_rdata >> NPORTS) == '0));

endmodule

bind hub_port_monitor hub_port_monitor_chk #(.NPORTS(NPORTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_reset  (bus_reset),
    .pkt_active (pkt_active),
    .eof2_strobe(eof2_strobe),
    .ds_nonidle (ds_nonidle),
    .us_linked  (us_linked),
    .conn       (conn_vec),
    .en         (en_vec),
    .hub_irq    (hub_irq),
    .drive_en   (drive_en),
    .drive_dp   (drive_dp),
    .drive_dm   (drive_dm),
    .reg_sel    (reg_sel),
    .reg_rdata  (reg_rdata)
);

// File: tb/sim_hub_port_monitor.sv
`timescale 1ns/1ps
module sim_hub_port_monitor;
    localparam int N    = 7;
    localparam int CONN = 30;
    localparam int DISC = 24;
    localparam int DW   = 2 * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_reset = 1'b0;
    logic [N-1:0]  line_dp = '0, line_dm = '0;
    logic          pkt_active = 1'b0, eof2_strobe = 1'b0;
    logic [N-1:0]  ds_nonidle = '0, us_linked = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          hub_irq;
    logic [N-1:0]  drive_en, drive_dp, drive_dm;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hub_port_monitor #(.NPORTS(N), .CONN_CYCLES(CONN), .DISC_CYCLES(DISC)) u0 (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .line_dp(line_dp), .line_dm(line_dm),
        .pkt_active(pkt_active), .eof2_strobe(eof2_strobe),
        .ds_nonidle(ds_nonidle), .us_linked(us_linked),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hub_irq(hub_irq),
        .drive_en(drive_en), .drive_dp(drive_dp), .drive_dm(drive_dm)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [DW-1:0] exp, input string req);
        reg_sel = s;
        #1;
        chk(32'(reg_rdata), 32'(exp), req);
    endtask

    task automatic done;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual running expected finished");
        done();
    end

    initial begin
        logic [N-1:0]  exp_conn, exp_spd;
        logic [DW-1:0] fv;
        exp_conn = '0;
        exp_spd  = '0;

        tick(3);
        rst = 1'b0;
        tick(1);
        for (int s = 0; s < 4; s++) rd_chk(2'(s), '0, "R1 reset reg");
        chk(32'(hub_irq), 0, "R1 irq");
        chk(32'(drive_en), 0, "R1 drive_en");

        // attach sweep: even ports full-speed, odd ports low-speed
        for (int p = 0; p < N; p++) begin
            logic s;
            s = 1'(p % 2);
            if (p == 0) begin
                line_dp[0] = 1'b1;
                tick(CONN - 1);
                rd_chk(2'd0, DW'(exp_conn), "R2 short run no attach");
                line_dp[0] = 1'b0;          // single SE0 sample restarts the filter
                tick(1);
            end
            line_dp[p] = ~s;
            line_dm[p] = s;
            tick(CONN - 1);
            rd_chk(2'd0, DW'(exp_conn), "R2 one sample early");
            chk(32'(hub_irq), 0, "R5 no irq early");
            tick(1);
            exp_conn[p] = 1'b1;
            exp_spd[p]  = s;
            rd_chk(2'd0, DW'(exp_conn), "R2 attach on due edge");
            chk(32'(hub_irq), 1, "R5 irq on attach, port disabled");
            rd_chk(2'd1, DW'(exp_spd), "R3 speed from idle line");
            tick(1);
            chk(32'(hub_irq), 0, "R5 irq one cycle");
        end

        // firmware speed override and detach
        wr(2'd1, DW'(7'h55));
        rd_chk(2'd1, DW'(7'h55), "R6 speed write");
        line_dp[2] = 1'b0; line_dm[2] = 1'b0;
        tick(DISC - 1);
        rd_chk(2'd0, DW'(7'h7F), "R4 still attached one early");
        tick(1);
        rd_chk(2'd0, DW'(7'h7B), "R4 detach on due edge");
        chk(32'(hub_irq), 1, "R5 irq on detach");
        rd_chk(2'd1, DW'(7'h55), "R4 speed kept on detach");
        line_dp[2] = 1'b1;
        tick(CONN);
        rd_chk(2'd1, DW'(7'h51), "R6 attach overwrites own bit only");
        rd_chk(2'd0, DW'(7'h7F), "R2 reattach");

        // write-ignore and reserved bits
        wr(2'd0, '0);
        rd_chk(2'd0, DW'(7'h7F), "R11 attach write ignored");
        wr(2'd1, '1);
        rd_chk(2'd1, DW'(7'h7F), "R11 speed reserved bits");
        wr(2'd2, ~DW'(7'h7F));
        rd_chk(2'd2, '0, "R11 enable reserved bits");

        // enable deferral
        wr(2'd2, DW'(7'h0F));
        rd_chk(2'd2, DW'(7'h0F), "R7 enable immediate when idle");
        pkt_active = 1'b1;
        wr(2'd2, DW'(7'h7E));
        rd_chk(2'd2, DW'(7'h0E), "R7 clear immediate, sets deferred");
        tick(3);
        rd_chk(2'd2, DW'(7'h0E), "R7 held during packet");
        pkt_active = 1'b0;
        tick(1);
        rd_chk(2'd2, DW'(7'h7E), "R7 applied at packet end");

        // babble
        ds_nonidle = 7'h04;
        tick(3);
        rd_chk(2'd2, DW'(7'h7E), "R8 no strobe no effect");
        ds_nonidle = 7'h02; us_linked = 7'h40; eof2_strobe = 1'b1;
        tick(1);
        eof2_strobe = 1'b0; ds_nonidle = '0; us_linked = '0;
        rd_chk(2'd2, DW'(7'h3C), "R8 babble clears enable");

        // force codes: port p gets code p mod 4
        wr(2'd3, '1);
        rd_chk(2'd3, '1, "R12 force full width");
        fv = '0;
        for (int p = 0; p < N; p++) fv[2*p +: 2] = 2'(p % 4);
        wr(2'd3, fv);
        rd_chk(2'd3, fv, "R12 force readback");
        for (int p = 0; p < N; p++) begin
            int c;
            c = p % 4;
            chk(32'(drive_en[p]), 32'(c != 0), "R9 drive_en");
            chk(32'(drive_dp[p]), 32'(c == 1), "R9 drive_dp");
            chk(32'(drive_dm[p]), 32'(c == 2), "R9 drive_dm");
        end

        // bus reset with a pending enable
        pkt_active = 1'b1;
        wr(2'd2, DW'(7'h7F));
        bus_reset = 1'b1;
        tick(1);
        bus_reset = 1'b0;
        pkt_active = 1'b0;
        rd_chk(2'd0, '0, "R10 attach cleared");
        rd_chk(2'd1, '0, "R10 speed cleared");
        rd_chk(2'd2, '0, "R10 enable cleared");
        rd_chk(2'd3, fv, "R10 force kept");
        chk(32'(hub_irq), 0, "R10 no irq");
        tick(1);
        rd_chk(2'd2, '0, "R10 pending enable dropped");
        tick(CONN - 2);
        rd_chk(2'd0, '0, "R10 detection restarts");
        tick(1);
        rd_chk(2'd0, DW'(7'h7F), "R10 reattach after bus reset");
        rd_chk(2'd1, DW'(7'h2A), "R3 speed after bus reset");

        // full reset clears force
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        rd_chk(2'd3, '0, "R1 force cleared by reset");
        chk(32'(drive_en), 0, "R1 drive released");

        done();
    end
endmodule